// File: doc/BRIEF.md
# Receiver Packet Sequencing Controller

This controller walks a low-power impulse receiver through the reception of one packet. While idle it holds the baseband in sleep with the receiver front end off. A receive request wakes the baseband. The controller then waits a programmable recovery time before it enables the correlator bank to search the preamble. The preamble is a run of repeated 31-chip code periods.

Acquisition stops at the first code period whose correlation peak magnitude is strictly above a programmable threshold. At that point the peak position is latched as the packet timing. A fixed channel estimation phase follows, then demodulation of the payload at four bits per clock. After the last payload word the receiver is switched off and sleep is asserted again in the same cycle, which keeps receiver on-time as short as possible.

If no period clears the threshold within a programmable number of periods, the controller gives up. It returns to sleep and raises an error flag.

Top module: `rx_sequencer`

## Requirements
- R1: After reset, and whenever idle, `sleep` is 1 and `rx_en`, `acq_en`, `chest_en`, `demod_en`, `done` and `err` are 0.
- R2: `start` seen while idle drops `sleep` in the next cycle. `acq_en` and `rx_en` rise exactly `recov_cyc`+1 cycles after `sleep` falls.
- R3: `start` is ignored while a packet is in progress, and the phase timing is unchanged.
- R4: A `corr_valid` cycle with `corr_mag` strictly greater than `thresh` ends acquisition; the next cycle shows `chest_en`=1 and `timing` equal to that cycle's `corr_pos`. A magnitude equal to or below `thresh` does not end acquisition, and `timing` changes at no other time.
- R5: When `max_periods` `corr_valid` cycles have passed without a peak (a value of 0 acts as 1), the next cycle is idle with `err`=1 for exactly one cycle and `done`=0.
- R6: Channel estimation (`chest_en`=1) lasts exactly `CHEST_CYC` cycles, and demodulation follows directly.
- R7: Demodulation (`demod_en`=1) lasts max(1, ceil(L/4)) cycles, where L is `pay_len` sampled with the accepted `start`. Later changes to `pay_len` have no effect.
- R8: When demodulation ends, the next cycle is idle with `done`=1 for exactly one cycle and `sleep`=1.
- R9: `rx_en` is 1 exactly while one of `acq_en`, `chest_en` or `demod_en` is 1. At most one of those three is 1 at a time, and `rx_en` is never 1 together with `sleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Receive request |
| recov_cyc | input | RW | Recovery wait after wake-up, in cycles |
| thresh | input | MW | Peak detection threshold |
| max_periods | input | PW | Code periods allowed before abort |
| pay_len | input | LW | Payload length in bits |
| corr_valid | input | 1 | One code period of correlation finished |
| corr_mag | input | MW | Peak magnitude for that period |
| corr_pos | input | IW | Peak position for that period |
| sleep | output | 1 | Baseband sleep control |
| rx_en | output | 1 | Receiver front end enable |
| acq_en | output | 1 | Correlator acquisition enable |
| chest_en | output | 1 | Channel estimation enable |
| demod_en | output | 1 | Combiner demodulation enable |
| done | output | 1 | One-cycle packet complete pulse |
| err | output | 1 | One-cycle acquisition timeout pulse |
| timing | output | IW | Latched peak position |

## Verification
Every result is due at a fixed distance from its cause:
- `sleep` falls one cycle after the accepted `start`.
- `acq_en` rises `recov_cyc`+1 cycles after that.
- `chest_en` and the latched timing, or the `err` pulse, appear one cycle after the deciding `corr_valid`.
- `done` appears one cycle after the last demodulation cycle.

The bench drives inputs and samples outputs on the falling edge. It counts the falling edges over which each phase enable stays high, and compares each count with a length computed from the programmed recovery, the estimation length and the rounded payload length. Each flag is checked in the cycle it is due and again in the cycle after, to confirm it is a single-cycle pulse.

// File: rtl/rx_sequencer.sv
module rx_sequencer #(
  parameter int RW = 8,
  parameter int LW = 12,
  parameter int PW = 6,
  parameter int MW = 8,
  parameter int IW = 10,
  parameter int CHEST_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] recov_cyc,
  input  logic [MW-1:0] thresh,
  input  logic [PW-1:0] max_periods,
  input  logic [LW-1:0] pay_len,
  input  logic          corr_valid,
  input  logic [MW-1:0] corr_mag,
  input  logic [IW-1:0] corr_pos,
  output logic          sleep,
  output logic          rx_en,
  output logic          acq_en,
  output logic          chest_en,
  output logic          demod_en,
  output logic          done,
  output logic          err,
  output logic [IW-1:0] timing
);
  localparam int CHW = $clog2(CHEST_CYC + 1);
  localparam int CW0 = (LW > RW) ? LW : RW;
  localparam int CW  = (CW0 > CHW) ? CW0 : CHW;

  typedef enum logic [2:0] {S_IDLE, S_RECOV, S_ACQ, S_CHEST, S_DEMOD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] per;
  logic [LW-1:0] len_q;
  logic [LW:0]   words;
  logic [LW:0]   words_m1;

  assign words    = ({1'b0, len_q} + (LW+1)'(3)) >> 2;
  assign words_m1 = (words == '0) ? '0 : words - 1'b1;

  assign sleep    = (st == S_IDLE);
  assign acq_en   = (st == S_ACQ);
  assign chest_en = (st == S_CHEST);
  assign demod_en = (st == S_DEMOD);
  assign rx_en    = acq_en | chest_en | demod_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      per    <= '0;
      len_q  <= '0;
      timing <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            st    <= S_RECOV;
            cnt   <= CW'(recov_cyc);
            len_q <= pay_len;
            per   <= '0;
          end
        S_RECOV:
          if (cnt == '0) st <= S_ACQ;
          else cnt <= cnt - 1'b1;
        S_ACQ:
          if (corr_valid) begin
            if (corr_mag > thresh) begin
              timing <= corr_pos;
              st     <= S_CHEST;
              cnt    <= CW'(CHEST_CYC - 1);
            end else if (({1'b0, per} + 1'b1) >= {1'b0, max_periods}) begin
              st  <= S_IDLE;
              err <= 1'b1;
            end else begin
              per <= per + 1'b1;
            end
          end
        S_CHEST:
          if (cnt == '0) begin
            st  <= S_DEMOD;
            cnt <= CW'(words_m1);
          end else cnt <= cnt - 1'b1;
        S_DEMOD:
          if (cnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SLEEP_NO_RX: assert property (@(posedge clk) disable iff (!rst_n) sleep |-> !rx_en); // R9
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({acq_en, chest_en, demod_en})); // R9
  AST_ACQ_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n) $rose(acq_en) |-> $past(st == S_RECOV)); // R2
  AST_ERR_FROM_ACQ: assert property (@(posedge clk) disable iff (!rst_n) err |-> ($past(acq_en) && sleep && !done)); // R5
  AST_DONE_FROM_DEMOD: assert property (@(posedge clk) disable iff (!rst_n) done |-> ($past(demod_en) && sleep)); // R8
  AST_TIMING_HELD: assert property (@(posedge clk) disable iff (!rst_n) !acq_en |=> $stable(timing)); // R4
  AST_CHEST_TO_DEMOD: assert property (@(posedge clk) disable iff (!rst_n) $fell(chest_en) |-> demod_en); // R6
endmodule

// File: tb/sim_rx_sequencer.sv
module sim_rx_sequencer;
  localparam int CHEST_CYC = 4;

  logic       clk = 0, rst_n = 0, start = 0, corr_valid = 0;
  logic [7:0] recov_cyc = 0, thresh = 0, corr_mag = 0;
  logic [5:0] max_periods = 0;
  logic [11:0] pay_len = 0;
  logic [9:0] corr_pos = 0;
  logic sleep, rx_en, acq_en, chest_en, demod_en, done, err;
  logic [9:0] timing;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rx_sequencer u0 (.clk(clk), .rst_n(rst_n), .start(start), .recov_cyc(recov_cyc),
    .thresh(thresh), .max_periods(max_periods), .pay_len(pay_len), .corr_valid(corr_valid),
    .corr_mag(corr_mag), .corr_pos(corr_pos), .sleep(sleep), .rx_en(rx_en), .acq_en(acq_en),
    .chest_en(chest_en), .demod_en(demod_en), .done(done), .err(err), .timing(timing));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_words(input int len);
    int w = (len + 3) / 4;
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int idle_bus();
    return {sleep, rx_en, acq_en, chest_en, demod_en, done, err};
  endfunction

  task automatic run_pkt(input int r, input int maxp, input int len, input int miss);
    int m = (maxp == 0) ? 1 : maxp;
    bit abort = (miss >= m);
    int nm = abort ? m : miss;
    int c;
    logic [7:0] thr = 8'(1 + $urandom % 200);
    logic [9:0] pos = 10'($urandom);
    @(negedge clk);
    chk(idle_bus() == 7'b1000000, "R1 idle outputs", idle_bus(), 7'b1000000);
    recov_cyc = 8'(r); max_periods = 6'(maxp); pay_len = 12'(len); thresh = thr; start = 1;
    @(negedge clk);
    start = 0;
    chk(!sleep && !acq_en && !rx_en, "R2 sleep falls, acq off", {sleep, acq_en, rx_en}, 0);
    start = 1;  // R3: second request during recovery
    c = 0;
    while (!acq_en && c < 400) begin
      @(negedge clk);
      start = 0;
      c++;
    end
    start = 0;
    chk(c == r + 1, "R2 R3 recovery length", c, r + 1);
    chk(rx_en && !sleep, "R9 rx_en with acquisition", rx_en, 1);
    for (int i = 0; i < nm; i++) begin
      repeat ($urandom % 3) @(negedge clk);
      corr_valid = 1;
      corr_mag = (i == 0) ? thr : 8'(thr - $urandom % (thr + 1));
      corr_pos = 10'($urandom);
      @(negedge clk);
      corr_valid = 0;
      if (abort && i == nm - 1) begin
        chk(sleep && err && !done && !rx_en, "R5 timeout abort", {sleep, err, done, rx_en}, 4'b1100);
        @(negedge clk);
        chk(!err && sleep, "R5 err single pulse", err, 0);
      end else begin
        chk(acq_en && rx_en, "R4 no peak at or below threshold", acq_en, 1);
      end
    end
    if (abort) return;
    repeat ($urandom % 3) @(negedge clk);
    corr_valid = 1;
    corr_mag = 8'(int'(thr) + 1 + $urandom % (255 - thr));
    corr_pos = pos;
    @(negedge clk);
    corr_valid = 0;
    corr_pos = ~pos;
    chk(chest_en && !acq_en, "R4 peak ends acquisition", chest_en, 1);
    chk(timing == pos, "R4 timing latched", timing, pos);
    pay_len = 12'($urandom);  // R7: late change must not matter
    c = 0;
    while (chest_en && c < 100) begin
      chk(rx_en, "R9 rx_en in estimation", rx_en, 1);
      @(negedge clk);
      c++;
    end
    chk(c == CHEST_CYC, "R6 estimation length", c, CHEST_CYC);
    chk(demod_en, "R6 demod follows", demod_en, 1);
    c = 0;
    while (demod_en && c < 2000) begin
      @(negedge clk);
      c++;
    end
    chk(c == exp_words(len), "R7 demod length", c, exp_words(len));
    chk(done && sleep && !rx_en && !err, "R8 done pulse", {done, sleep, rx_en, err}, 4'b1100);
    chk(timing == pos, "R4 timing held", timing, pos);
    @(negedge clk);
    chk(!done, "R8 done single pulse", done, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd2468));
    repeat (3) @(negedge clk);
    chk(idle_bus() == 7'b1000000, "R1 reset state", idle_bus(), 7'b1000000);
    rst_n = 1;
    run_pkt(0, 5, 0, 0);
    run_pkt(3, 5, 1, 2);
    run_pkt(1, 4, 4, 3);
    run_pkt(2, 4, 5, 0);
    run_pkt(0, 0, 8, 1);
    run_pkt(5, 3, 16, 3);
    run_pkt(0, 1, 7, 0);
    for (int k = 0; k < 40; k++)
      run_pkt($urandom % 20, $urandom % 8, $urandom % 300, $urandom % 9);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule